// File: doc/BRIEF.md
# Partial-tag counting Bloom miss predictor

This block sits beside one way of a set-associative cache. It tells the lookup path, before any tag-array read, whether an address is certainly absent from that way. It keeps a small array of counting entries. Each entry holds a counter, a flag for a count of zero, a flag for a count of one and an accumulated 3-bit partial tag. A line fill into the way adds the incoming tag to the entry its hash selects: the counter goes up and the partial tag is XORed with the line's partial tag. An eviction removes the outgoing tag the same way, with the counter going down.

A query returns either "definite miss" or "likely hit". A count of zero proves a miss. When exactly one line maps to the entry, the accumulated partial tag equals that line's partial tag. A partial-tag mismatch then also proves a miss, although the count is non-zero. Every other case returns likely hit, and the full tag compare must still be done. The key fed to the block is the slice of the cache tag it looks at. The low `NUM_HASH*IDX_W` bits form the hash indices, one `IDX_W`-bit slice per hash function. The `PT_W` bits above them form the partial tag. With the default parameters (one hash, `IDX_W`=5, `PT_W`=3, `CNT_W`=4) the key is 8 bits: index = key[4:0] and partial tag = key[7:5].

Top module: `ptagMissFilter`

## Requirements
- R1: After reset every entry is empty. `respValid` is low until a query is issued, and every query then answers miss (`respMiss`=1).
- R2: A query presented with `queryValid` high in cycle t is answered in cycle t+1 with `respValid`=1, for the key presented in cycle t. `respValid` is low in a cycle that follows a cycle without a query.
- R3: A query whose selected entry has a count of zero returns `respMiss`=1.
- R4: A fill increments the count of the entry indexed by key[IDX_W-1:0] and XORs that entry's partial tag with key[IDX_W+PT_W-1:IDX_W].
- R5: An eviction decrements the count of the entry its key indexes and XORs the entry's partial tag with the evicted key's partial tag.
- R6: When the selected entry (every selected entry, for more than one hash) has a count of exactly one, the query returns miss if the stored partial tag differs from the query's partial tag, and likely hit (`respMiss`=0) if it matches.
- R7: A query whose entry has a count of two or more returns likely hit, whatever its partial tag.
- R8: After fills and evictions to one entry in the order A1 in, A3 in, A5 in, A3 out, A2 in, A1 out, A5 out, the entry answers likely hit for A2's partial tag and miss for any other partial tag.
- R9: A fill or eviction issued in the same cycle as a query takes effect first. The response in the next cycle reflects the updated entry.
- R10: A count that reaches its maximum (2^CNT_W-1) stays there: further fills and evictions leave it unchanged, and the entry always answers likely hit.
- R11: An eviction aimed at an entry with a count of zero is ignored. The count stays zero and the partial tag is unchanged.
- R12: A fill and an eviction in the same cycle are both applied. On the same entry the count is unchanged and the partial tag is XORed with both partial tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fillValid | input | 1 | A line is filled into the way this cycle |
| fillTag | input | NUM_HASH*IDX_W+PT_W | Key of the filled line |
| evictValid | input | 1 | A line leaves the way this cycle |
| evictTag | input | NUM_HASH*IDX_W+PT_W | Key of the evicted line |
| queryValid | input | 1 | Membership query this cycle |
| queryTag | input | NUM_HASH*IDX_W+PT_W | Key being queried |
| respValid | output | 1 | Answer to last cycle's query is present |
| respMiss | output | 1 | 1 = definite miss, 0 = likely hit (valid with respValid) |

## Verification
On every cycle, the assertions check three things for each entry. The one-cycle query pipeline holds the key it captured. A lone fill raises the count by one and folds in the partial tag. A saturated count or an eviction of an empty entry never moves the count. Only the bench's scenarios can show that the combined answer is right. This covers the singleton partial-tag test, the seven-step fill and eviction order, updates that race a query, and paired fill and eviction on one entry. The bench checks these against a model of counts and partial tags built from the requirements.

// File: rtl/ptagFilterPkg.sv
package ptagFilterPkg;
  typedef struct packed {
    logic incEn;   // apply a fill this cycle
    logic decEn;   // apply an eviction this cycle
    logic lookEn;  // a captured query is answered this cycle
  } filterStrobe_t;
endpackage

// File: rtl/ptagFilterCtrl.sv
module ptagFilterCtrl
  import ptagFilterPkg::*;
#(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillValid,
  input  logic             evictValid,
  input  logic             queryValid,
  input  logic [KEY_W-1:0] queryTag,
  output filterStrobe_t    strobe,
  output logic [KEY_W-1:0] lookTag
);
  logic             qPend;
  logic [KEY_W-1:0] qTagQ;

  // Updates act at this edge; the captured query is answered next cycle,
  // so it always observes them.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qPend <= 1'b0;
      qTagQ <= '0;
    end else begin
      qPend <= queryValid;
      if (queryValid) qTagQ <= queryTag;
    end
  end

  always_comb begin
    strobe.incEn  = fillValid;
    strobe.decEn  = evictValid;
    strobe.lookEn = qPend;
  end
  assign lookTag = qTagQ;

  AST_QUERY_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    queryValid |=> strobe.lookEn); // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !queryValid |=> !strobe.lookEn); // R2
  AST_KEY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    queryValid |=> (lookTag == $past(queryTag))); // R2
endmodule

// File: rtl/ptagFilterDatapath.sv
module ptagFilterDatapath
  import ptagFilterPkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int CNT_W    = 4,
  parameter int PT_W     = 3,
  parameter int NUM_HASH = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  filterStrobe_t                 strobe,
  input  logic [NUM_HASH*IDX_W+PT_W-1:0] fillTag,
  input  logic [NUM_HASH*IDX_W+PT_W-1:0] evictTag,
  input  logic [NUM_HASH*IDX_W+PT_W-1:0] lookTag,
  output logic                          lookMiss
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int PT_LSB  = NUM_HASH * IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cntQ   [ENTRIES];
  logic             zeroQ  [ENTRIES];
  logic             singleQ[ENTRIES];
  logic [PT_W-1:0]  ptagQ  [ENTRIES];

  logic [IDX_W-1:0] fillIdx [NUM_HASH];
  logic [IDX_W-1:0] evictIdx[NUM_HASH];
  logic [IDX_W-1:0] lookIdx [NUM_HASH];
  logic [ENTRIES-1:0] fillSel, evictSel;
  logic [PT_W-1:0] fillPt, evictPt, lookPt;

  assign fillPt  = fillTag [PT_LSB +: PT_W];
  assign evictPt = evictTag[PT_LSB +: PT_W];
  assign lookPt  = lookTag [PT_LSB +: PT_W];

  // Bit-slice hashes; an entry chosen by several hashes is updated once.
  always_comb begin
    fillSel  = '0;
    evictSel = '0;
    for (int h = 0; h < NUM_HASH; h++) begin
      fillIdx[h]  = fillTag [h*IDX_W +: IDX_W];
      evictIdx[h] = evictTag[h*IDX_W +: IDX_W];
      lookIdx[h]  = lookTag [h*IDX_W +: IDX_W];
      fillSel[fillIdx[h]]   = strobe.incEn;
      evictSel[evictIdx[h]] = strobe.decEn;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    logic             incApplied, decApplied;
    logic [CNT_W-1:0] cntNext;
    logic [PT_W-1:0]  ptNext;

    always_comb begin
      incApplied = fillSel[e] && (cntQ[e] != CNT_MAX);
      decApplied = evictSel[e] && (cntQ[e] != '0) && (cntQ[e] != CNT_MAX);
      cntNext = cntQ[e] + {{(CNT_W-1){1'b0}}, incApplied}
                        - {{(CNT_W-1){1'b0}}, decApplied};
      ptNext = ptagQ[e] ^ (incApplied ? fillPt : '0) ^ (decApplied ? evictPt : '0);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ[e]    <= '0;
        zeroQ[e]   <= 1'b1;
        singleQ[e] <= 1'b0;
        ptagQ[e]   <= '0;
      end else if (fillSel[e] || evictSel[e]) begin
        cntQ[e]    <= cntNext;
        zeroQ[e]   <= (cntNext == '0);
        singleQ[e] <= (cntNext == CNT_W'(1));
        ptagQ[e]   <= ptNext;
      end
    end

    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rstN)
      (fillSel[e] && !evictSel[e] && cntQ[e] != CNT_MAX)
        |=> (cntQ[e] == $past(cntQ[e]) + CNT_W'(1))); // R4
    AST_FILL_PTAG: assert property (@(posedge clk) disable iff (!rstN)
      (fillSel[e] && !evictSel[e] && cntQ[e] != CNT_MAX)
        |=> (ptagQ[e] == ($past(ptagQ[e]) ^ $past(fillPt)))); // R4
    AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (cntQ[e] == CNT_MAX) |=> (cntQ[e] == CNT_MAX)); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      (cntQ[e] == '0 && !fillSel[e]) |=> (cntQ[e] == '0 && $stable(ptagQ[e]))); // R11
  end

  // Query: empty -> miss; all singletons with a foreign partial tag -> miss.
  logic anyZero, allSingle, ptMismatch;
  always_comb begin
    anyZero    = 1'b0;
    allSingle  = 1'b1;
    ptMismatch = 1'b0;
    for (int h = 0; h < NUM_HASH; h++) begin
      anyZero    = anyZero | zeroQ[lookIdx[h]];
      allSingle  = allSingle & singleQ[lookIdx[h]];
      ptMismatch = ptMismatch | (ptagQ[lookIdx[h]] != lookPt);
    end
    lookMiss = anyZero || (allSingle && ptMismatch);
  end
endmodule

// File: rtl/ptagMissFilter.sv
module ptagMissFilter
  import ptagFilterPkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int CNT_W    = 4,
  parameter int PT_W     = 3,
  parameter int NUM_HASH = 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           fillValid,
  input  logic [NUM_HASH*IDX_W+PT_W-1:0] fillTag,
  input  logic                           evictValid,
  input  logic [NUM_HASH*IDX_W+PT_W-1:0] evictTag,
  input  logic                           queryValid,
  input  logic [NUM_HASH*IDX_W+PT_W-1:0] queryTag,
  output logic                           respValid,
  output logic                           respMiss
);
  localparam int KEY_W = NUM_HASH * IDX_W + PT_W;

  filterStrobe_t    strobe;
  logic [KEY_W-1:0] lookTag;
  logic             lookMiss;

  ptagFilterCtrl #(.KEY_W(KEY_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .fillValid(fillValid), .evictValid(evictValid),
    .queryValid(queryValid), .queryTag(queryTag),
    .strobe(strobe), .lookTag(lookTag)
  );

  ptagFilterDatapath #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .PT_W(PT_W), .NUM_HASH(NUM_HASH)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fillTag(fillTag), .evictTag(evictTag), .lookTag(lookTag),
    .lookMiss(lookMiss)
  );

  assign respValid = strobe.lookEn;
  assign respMiss  = strobe.lookEn && lookMiss;
endmodule

// File: tb/ptagMissFilter_bench.sv
module ptagMissFilter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 32;
  localparam int CMAX = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fillValid = 0, evictValid = 0, queryValid = 0;
  logic [7:0] fillTag = '0, evictTag = '0, queryTag = '0;
  logic respValid, respMiss;

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;
  int mCnt[ENTRIES];
  int mPt[ENTRIES];
  logic [7:0] resident[64];
  int numRes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptagMissFilter u_ptagMissFilter (
    .clk(clk), .rstN(rstN),
    .fillValid(fillValid), .fillTag(fillTag),
    .evictValid(evictValid), .evictTag(evictTag),
    .queryValid(queryValid), .queryTag(queryTag),
    .respValid(respValid), .respMiss(respMiss)
  );

  function automatic logic [7:0] key(input int pt, input int idx);
    return {3'(pt), 5'(idx)};
  endfunction

  function automatic bit expectMiss(input logic [7:0] k);
    int c = mCnt[k[4:0]];
    return (c == 0) || (c == 1 && mPt[k[4:0]] != int'(k[7:5]));
  endfunction

  task automatic applyOne(input int i, input bit inc, input int ip, input bit dec, input int dp);
    bit incA = inc && mCnt[i] != CMAX;
    bit decA = dec && mCnt[i] != 0 && mCnt[i] != CMAX;
    mCnt[i] = mCnt[i] + int'(incA) - int'(decA);
    if (incA) mPt[i] = mPt[i] ^ ip;
    if (decA) mPt[i] = mPt[i] ^ dp;
  endtask

  task automatic modelUpdate(input bit fv, input logic [7:0] ft, input bit ev, input logic [7:0] et);
    if (fv && ev && ft[4:0] == et[4:0]) applyOne(ft[4:0], 1, ft[7:5], 1, et[7:5]);
    else begin
      if (fv) applyOne(ft[4:0], 1, ft[7:5], 0, 0);
      if (ev) applyOne(et[4:0], 0, 0, 1, et[7:5]);
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit fv, input logic [7:0] ft, input bit ev, input logic [7:0] et,
                      input bit qv, input logic [7:0] qt, input string req);
    bit em;
    @(negedge clk);
    fillValid = fv; fillTag = ft; evictValid = ev; evictTag = et;
    queryValid = qv; queryTag = qt;
    @(posedge clk);
    #1;
    modelUpdate(fv, ft, ev, et);
    if (qv) begin
      em = expectMiss(qt);
      check(respValid === 1'b1, {req, " respValid"}, int'(respValid), 1);
      check(respMiss === em, {req, " respMiss"}, int'(respMiss), int'(em));
    end else begin
      check(respValid === 1'b0, "R2 idle respValid", int'(respValid), 0);
    end
  endtask

  task automatic fill(input logic [7:0] k);  step(1, k, 0, '0, 0, '0, "R4 fill"); endtask
  task automatic evict(input logic [7:0] k); step(0, '0, 1, k, 0, '0, "R5 evict"); endtask
  task automatic query(input logic [7:0] k, input string req); step(0, '0, 0, '0, 1, k, req); endtask

  // Directed expectation besides the model: name the literal answer too.
  task automatic queryExpect(input logic [7:0] k, input bit exp, input string req);
    query(k, req);
    check(respMiss === exp, {req, " literal"}, int'(respMiss), int'(exp));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2024));
    for (int i = 0; i < ENTRIES; i++) begin mCnt[i] = 0; mPt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(respValid === 1'b0, "R1 respValid after reset", int'(respValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(respValid === 1'b0, "R1 respValid idle", int'(respValid), 0);

    // R1 / R3: empty filter misses everything
    for (int i = 0; i < 6; i++) queryExpect(8'($urandom), 1'b1, "R1 R3 empty miss");

    // R8: A1,A3,A5 in, A3 out, A2 in, A1 out, A5 out on entry 5
    fill(key(1, 5)); fill(key(3, 5)); fill(key(5, 5));
    evict(key(3, 5));
    queryExpect(key(7, 5), 1'b0, "R7 count two likely hit");
    fill(key(2, 5)); evict(key(1, 5)); evict(key(5, 5));
    queryExpect(key(2, 5), 1'b0, "R8 singleton A2 hit");
    queryExpect(key(6, 5), 1'b1, "R8 R6 singleton mismatch miss");
    evict(key(2, 5));
    queryExpect(key(2, 5), 1'b1, "R5 R3 emptied entry miss");

    // R10: saturation on entry 9
    for (int i = 0; i < 17; i++) fill(key(i % 8, 9));
    for (int i = 0; i < 20; i++) evict(key(i % 8, 9));
    queryExpect(key(3, 9), 1'b0, "R10 saturated hit");

    // R11: evictions of an empty entry 12 are ignored
    for (int i = 0; i < 3; i++) evict(key(4, 12));
    queryExpect(key(4, 12), 1'b1, "R11 still empty");
    fill(key(6, 12));
    queryExpect(key(6, 12), 1'b0, "R11 ptag untouched hit");
    queryExpect(key(4, 12), 1'b1, "R11 ptag untouched miss");

    // R12: fill and eviction together on entry 20
    fill(key(1, 20));
    step(1, key(3, 20), 1, key(1, 20), 0, '0, "R12 swap");
    queryExpect(key(3, 20), 1'b0, "R12 swapped in hit");
    queryExpect(key(1, 20), 1'b1, "R12 swapped out miss");

    // R9: update and query in one cycle
    step(1, key(2, 25), 0, '0, 1, key(2, 25), "R9 fill with query");
    check(respMiss === 1'b0, "R9 fill seen", int'(respMiss), 0);
    step(0, '0, 1, key(2, 25), 1, key(2, 25), "R9 evict with query");
    check(respMiss === 1'b1, "R9 evict seen", int'(respMiss), 1);

    // R2: back-to-back queries then idle
    query(key(6, 12), "R2 back to back a");
    query(key(0, 3), "R2 back to back b");
    step(0, '0, 0, '0, 0, '0, "R2 idle");

    // Random mix of fills, evictions of resident lines and queries
    for (int n = 0; n < 3000; n++) begin
      bit fv, ev, qv;
      logic [7:0] ft, et, qt;
      int pick;
      fv = ($urandom % 3 == 0) && numRes < 48;
      ev = ($urandom % 3 == 0) && numRes > 0;
      qv = ($urandom % 2 == 0);
      ft = 8'($urandom);
      et = '0;
      if (ev) begin
        pick = int'($urandom % numRes);
        et = resident[pick];
        resident[pick] = resident[numRes-1];
        numRes--;
      end
      if (fv) begin resident[numRes] = ft; numRes++; end
      qt = (numRes > 0 && $urandom % 2 == 0) ? resident[$urandom % numRes] : 8'($urandom);
      step(fv, ft, ev, et, qv, qt, "R6 R7 R12 random");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule